// File: doc/BRIEF.md
# Drift-Tolerant Serial Byte Receiver

This block receives asynchronous serial frames of eight data bits, one stop bit and no parity on a single input line. It keeps the most recently completed byte for a processor load port. The bit time comes from two parameters, the system clock rate and the line rate. The clock divider is derived from them by rounding: `round(ClkHz / Baud)` clock cycles per bit. With the defaults this is 174 cycles.

The line first passes through a two-flop synchronizer. A low level confirmed at the middle of the start bit begins a frame. Each data bit is sampled at its centre, least significant bit first. The byte is delivered when the last data bit is sampled.

After delivery the receiver waits for one more bit time. That wait covers only the first half of the stop bit, so the receiver rearms early. If the line falls during this wait, the receiver treats the fall as a sender running slightly fast and starts timing a new start bit at once.

A processor reads the port as a halfword or as a byte. In halfword view, an empty port reads as all ones. A present byte reads zero-extended, so a received zero is still distinguishable. A read strobe consumes the byte. If a byte completes while the previous one is unread, the new byte replaces it and a sticky overrun flag is set.

Top module: `serial_rx_port`

## Requirements
- R1: Asynchronous active-low reset leaves the receiver idle with `byte_ready`=0, `overrun`=0 and a halfword read of 0xFFFF.
- R2: A frame with eight data bits (least significant bit first, each sampled at its centre) and one high stop bit sets `byte_ready`=1 before the stop bit ends.
- R3: In halfword view (`rd_half`=1), `rd_data` is 0xFFFF when no byte is waiting. Otherwise it is 0x00 in bits 15:8 and the byte in bits 7:0, and a received 0x00 reads as 0x0000.
- R4: In byte view (`rd_half`=0), bits 15:8 are always 0x00. Bits 7:0 hold the byte when one is waiting, and 0xFF otherwise.
- R5: A cycle with `rd_en`=1 and no byte completing clears `byte_ready` on that clock edge.
- R6: A byte that completes while `byte_ready`=1 and `rd_en`=0 sets `overrun`, and the new byte replaces the old one. `overrun` stays set until reset.
- R7: A low pulse shorter than half a bit that is high again at the start-bit midpoint produces no byte, and the receiver returns to idle.
- R8: A falling edge during the wait after the last data bit starts a new frame, so a frame whose stop bit lasts only about a third of a bit is still followed by a correctly received next frame.
- R9: Back-to-back frames sent about 2% fast or 2% slow against the nominal bit time are all received, with no lost byte and no overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial receive line, idle high |
| rd_en | input | 1 | Read strobe; consumes the waiting byte |
| rd_half | input | 1 | 1 = halfword view, 0 = byte view |
| rd_data | output | 16 | Read value as given by R3/R4 |
| byte_ready | output | 1 | A received byte is waiting |
| overrun | output | 1 | Sticky: a byte was replaced before being read |

## Verification
A wrong phase in the bit counter shows up within one frame as a shifted or wrong byte in `rd_data`, most visibly at 2% rate error, where the sampling margin is thin. A stuck data-valid state shows on the next read strobe as a missing 0xFFFF. A stop wait that is too long or blind to edges loses the second of two closely spaced frames. A false-start path that does not return to idle leaves a spurious byte within one frame time of a short glitch.

// File: rtl/serial_rx_port.sv
module serial_rx_port #(
  parameter int unsigned ClkHz = 20_000_000,
  parameter int unsigned Baud  = 115_200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_line,
  input  logic        rd_en,
  input  logic        rd_half,
  output logic [15:0] rd_data,
  output logic        byte_ready,
  output logic        overrun
);

  localparam int unsigned BitCycles  = (ClkHz + Baud / 2) / Baud;
  localparam int unsigned HalfCycles = BitCycles / 2;
  localparam int unsigned CntW       = $clog2(BitCycles + 1);
  localparam logic [CntW-1:0] BitLast  = CntW'(BitCycles - 1);
  localparam logic [CntW-1:0] HalfLast = CntW'(HalfCycles - 1);

  typedef enum logic [1:0] {Idle, Start, Data, Stop} rx_state_e;

  rx_state_e       state;
  logic [CntW-1:0] cnt;
  logic [2:0]      bit_idx;
  logic [7:0]      shreg;
  logic [7:0]      held;
  logic [1:0]      sync;
  logic            rx_prev;

  wire rx_s    = sync[1];
  wire fall    = rx_prev & ~rx_s;
  wire bit_end = (cnt == BitLast);
  wire done    = (state == Data) && bit_end && (bit_idx == 3'd7);

  assign rd_data = byte_ready ? {8'h00, held} : (rd_half ? 16'hFFFF : 16'h00FF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      rx_prev <= 1'b1;
    end else begin
      sync    <= {sync[0], rx_line};
      rx_prev <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= Idle;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
    end else begin
      unique case (state)
        Idle: begin
          cnt <= '0;
          if (!rx_s) state <= Start;
        end
        Start: begin
          if (cnt == HalfLast) begin
            cnt     <= '0;
            bit_idx <= '0;
            state   <= rx_s ? Idle : Data;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        Data: begin
          if (bit_end) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[7:1]};
            if (bit_idx == 3'd7) state <= Stop;
            else bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        Stop: begin
          if (fall) begin
            cnt   <= '0;
            state <= Start;
          end else if (bit_end) begin
            cnt   <= '0;
            state <= Idle;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= Idle;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held       <= '0;
      byte_ready <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (done) begin
        held       <= {rx_s, shreg[7:1]};
        byte_ready <= 1'b1;
        if (byte_ready && !rd_en) overrun <= 1'b1;
      end else if (rd_en) begin
        byte_ready <= 1'b0;
      end
    end
  end

  AST_BYTE_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_ready) |-> $past(state) == Data); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !done) |=> !byte_ready); // R5
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R6
  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(byte_ready)); // R6
  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == Start && cnt == HalfLast && rx_s) |=> state == Idle); // R7
  AST_STOP_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (state == Stop && fall) |=> state == Start); // R8

endmodule

// File: tb/serial_rx_port_tb.sv
module serial_rx_port_tb;
  localparam int BIT = 174;

  logic clk = 1'b0, rst_n = 1'b0, rx_line = 1'b1, rd_en = 1'b0, rd_half = 1'b1;
  logic [15:0] rd_data;
  logic byte_ready, overrun;
  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] got [8];
  int ngot;

  serial_rx_port u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rd_en(rd_en), .rd_half(rd_half),
    .rd_data(rd_data), .byte_ready(byte_ready), .overrun(overrun)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_line = 1'b1; rd_en = 1'b0; rd_half = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input int per, input int stop_len);
    rx_line = 1'b0; repeat (per) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i]; repeat (per) @(negedge clk);
    end
    rx_line = 1'b1; repeat (stop_len) @(negedge clk);
  endtask

  task automatic read_pulse();
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic collect(input int n);
    ngot = 0;
    for (int c = 0; c < 30000 && ngot < n; c++) begin
      @(negedge clk);
      if (byte_ready) begin
        got[ngot] = rd_data[7:0];
        ngot++;
        read_pulse();
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 ready", {15'd0, byte_ready}, 16'd0);
    check("R1 overrun", {15'd0, overrun}, 16'd0);
    check("R1 empty read", rd_data, 16'hFFFF);
  endtask

  task automatic t_single();
    do_reset();
    send(8'hA5, BIT, BIT);
    check("R2 ready after frame", {15'd0, byte_ready}, 16'd1);
    check("R3 halfword byte", rd_data, 16'h00A5);
    rd_half = 1'b0; #1;
    check("R4 byte view", rd_data, 16'h00A5);
    rd_half = 1'b1;
    read_pulse();
    check("R5 cleared by read", {15'd0, byte_ready}, 16'd0);
    check("R3 empty after read", rd_data, 16'hFFFF);
    rd_half = 1'b0; #1;
    check("R4 byte view empty", rd_data, 16'h00FF);
    rd_half = 1'b1;
  endtask

  task automatic t_zero();
    do_reset();
    send(8'h00, BIT, BIT);
    check("R3 zero byte ready", {15'd0, byte_ready}, 16'd1);
    check("R3 zero byte value", rd_data, 16'h0000);
    read_pulse();
  endtask

  task automatic t_overrun();
    do_reset();
    send(8'h11, BIT, BIT);
    send(8'h22, BIT, BIT);
    check("R6 overrun set", {15'd0, overrun}, 16'd1);
    check("R6 newest byte kept", rd_data, 16'h0022);
    read_pulse();
    repeat (3) @(negedge clk);
    check("R6 overrun sticky", {15'd0, overrun}, 16'd1);
  endtask

  task automatic t_glitch();
    do_reset();
    rx_line = 1'b0; repeat (40) @(negedge clk);
    rx_line = 1'b1; repeat (3 * BIT) @(negedge clk);
    check("R7 no byte from glitch", {15'd0, byte_ready}, 16'd0);
    check("R7 empty after glitch", rd_data, 16'hFFFF);
    send(8'h3C, BIT, BIT);
    check("R7 next frame ok", rd_data, 16'h003C);
    read_pulse();
  endtask

  task automatic t_resync();
    do_reset();
    fork
      begin send(8'h5A, BIT, 60); send(8'hC3, BIT, BIT); end
      collect(2);
    join
    check("R8 count", 16'(ngot), 16'd2);
    check("R8 first", {8'h00, got[0]}, 16'h005A);
    check("R8 second after short stop", {8'h00, got[1]}, 16'h00C3);
    check("R8 no overrun", {15'd0, overrun}, 16'd0);
  endtask

  task automatic t_rate(input int per, input string tag);
    logic [7:0] pat [4] = '{8'h81, 8'h7E, 8'hF0, 8'h0F};
    do_reset();
    fork
      begin
        for (int k = 0; k < 4; k++) send(pat[k], per, per);
      end
      collect(4);
    join
    check({tag, " count"}, 16'(ngot), 16'd4);
    for (int k = 0; k < 4; k++) check({tag, " byte"}, {8'h00, got[k]}, {8'h00, pat[k]});
    check({tag, " no overrun"}, {15'd0, overrun}, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_zero();
    t_overrun();
    t_glitch();
    t_resync();
    t_rate(BIT, "R9 nominal");
    t_rate(170, "R9 fast");
    t_rate(178, "R9 slow");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule